// File: doc/BRIEF.md
# Out-of-Order Completion Buffer with In-Order Retirement

This block sits between instruction dispatch and the architectural register file. Dispatch presents instructions in program order. Each accepted instruction takes the slot at the tail of a circular buffer, and the slot index comes back on the same cycle as a tag. Execution units return a result and a fault flag against that tag whenever they finish, in any order. A finished result is held in its slot and never goes straight to the register file.

Retirement looks only at the oldest slot. A finished, fault-free oldest entry is retired, and it drives the register-file write port if it carries a write enable. If the oldest entry finished with a fault, the block does not retire it. Instead it raises a one-cycle fault pulse carrying that entry's tag and throws away every outstanding entry. The register file then holds the effect of everything older than the fault and nothing of the fault or anything younger. The tail returns to the faulting slot.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `rob_empty`=1, `disp_ready`=1, `disp_tag`=0, `rf_we`=0 and `exc_valid`=0.
- R2: `disp_tag` shows the slot the next dispatch will take. A dispatch is accepted in any cycle with `disp_valid` and `disp_ready` both high. Each accepted dispatch advances the tag by one modulo DEPTH.
- R3: With DEPTH entries outstanding, `disp_ready` is 0, and a dispatch request changes nothing (`disp_tag` stays put).
- R4: A completion (`cmp_valid`, `cmp_tag`, `cmp_value`, `cmp_fault`) only marks its slot finished. While the oldest entry is unfinished, no completion of a younger entry causes a register-file write.
- R5: When the oldest entry is finished without a fault, it retires that cycle. If its write enable is set, `rf_we`=1 with `rf_addr`/`rf_data` equal to its destination and result. At most one entry retires per cycle, and retirement follows dispatch order.
- R6: A finished oldest entry dispatched with `disp_wen`=0 retires and frees its slot with `rf_we`=0.
- R7: When the oldest entry is finished with a fault, `exc_valid` is 1 for exactly one cycle with `exc_tag` equal to its slot, and `rf_we` is 0. A fault on a younger entry has no visible effect while an older entry is still outstanding.
- R8: The cycle after `exc_valid`, the buffer is empty and `disp_tag` equals the faulting tag. None of the discarded entries ever writes the register file.
- R9: A completion addressed to a slot that holds no outstanding entry is ignored. A later dispatch into that slot starts unfinished.
- R10: In the cycle `exc_valid` is 1, `disp_ready` is 0.
- R11: While the buffer is empty, nothing retires and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch request |
| disp_dest | input | REG_W | Destination register of the dispatched instruction |
| disp_wen | input | 1 | Dispatched instruction writes a register |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_tag | output | TAG_W | Slot taken by a dispatch this cycle |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | TAG_W | Slot being completed |
| cmp_value | input | DATA_W | Result value |
| cmp_fault | input | 1 | Instruction raised a fault |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | REG_W | Register-file write address |
| rf_data | output | DATA_W | Register-file write data |
| exc_valid | output | 1 | One-cycle fault pulse |
| exc_tag | output | TAG_W | Slot of the faulting entry |
| rob_empty | output | 1 | No entries outstanding |

## Verification
Retirement of the oldest entry can fall in the same cycle as a dispatch into the tail and a completion of some younger slot. The random phase keeps the buffer partly full with frequent dispatches and completions, so these coincide often. A bench model applies all three events in one step and compares every output each cycle. A fault reaching the oldest slot can also meet a dispatch request and a completion in one cycle. Directed sequences set this up with a younger fault that is already finished. The bench expects the dispatch to be refused, the completion to be dropped and the buffer to be empty on the following cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef struct packed {
        logic valid;
        logic done;
        logic fault;
        logic wen;
    } rob_flags_t;

    typedef enum logic [1:0] {
        HEAD_IDLE,
        HEAD_WAIT,
        HEAD_RETIRE,
        HEAD_FAULT
    } head_state_e;

endpackage

// File: rtl/rob_slot.sv
module rob_slot
    import rob_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              alloc_i,
    input  logic [REG_W-1:0]  alloc_dest_i,
    input  logic              alloc_wen_i,
    input  logic              fill_i,
    input  logic [DATA_W-1:0] fill_value_i,
    input  logic              fill_fault_i,
    input  logic              retire_i,
    output rob_flags_t        flags_o,
    output logic [REG_W-1:0]  dest_o,
    output logic [DATA_W-1:0] value_o
);

    typedef struct packed {
        rob_flags_t        flags;
        logic [REG_W-1:0]  dest;
        logic [DATA_W-1:0] value;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.flags.valid = 1'b0;
        end else if (alloc_i) begin
            s_d.flags.valid = 1'b1;
            s_d.flags.done  = 1'b0;
            s_d.flags.fault = 1'b0;
            s_d.flags.wen   = alloc_wen_i;
            s_d.dest        = alloc_dest_i;
            s_d.value       = '0;
        end else if (retire_i) begin
            s_d.flags.valid = 1'b0;
        end else if (fill_i && s_q.flags.valid) begin
            s_d.flags.done  = 1'b1;
            s_d.flags.fault = fill_fault_i;
            s_d.value       = fill_value_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags_o = s_q.flags;
    assign dest_o  = s_q.dest;
    assign value_o = s_q.value;

endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = TAG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             head_valid_i,
    input  logic             head_done_i,
    input  logic             head_fault_i,
    output logic [TAG_W-1:0] head_o,
    output logic [TAG_W-1:0] tail_o,
    output logic             accept_o,
    output logic             commit_o,
    output logic             flush_o,
    output logic             ready_o,
    output logic             empty_o
);

    typedef struct packed {
        logic [TAG_W-1:0] head;
        logic [TAG_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_t;

    ptr_t        p_d, p_q;
    head_state_e status;

    always_comb begin
        if (!head_valid_i)     status = HEAD_IDLE;
        else if (!head_done_i) status = HEAD_WAIT;
        else if (head_fault_i) status = HEAD_FAULT;
        else                   status = HEAD_RETIRE;

        commit_o = (status == HEAD_RETIRE);
        flush_o  = (status == HEAD_FAULT);
        ready_o  = (p_q.count != CNT_W'(DEPTH)) && !flush_o;
        accept_o = req_i && ready_o;

        p_d = p_q;
        if (flush_o) begin
            p_d.tail  = p_q.head;
            p_d.count = '0;
        end else begin
            if (commit_o) p_d.head = p_q.head + 1'b1;
            if (accept_o) p_d.tail = p_q.tail + 1'b1;
            p_d.count = p_q.count + CNT_W'(accept_o) - CNT_W'(commit_o);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign head_o  = p_q.head;
    assign tail_o  = p_q.tail;
    assign empty_o = (p_q.count == '0);

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [REG_W-1:0]  disp_dest,
    input  logic              disp_wen,
    output logic              disp_ready,
    output logic [TAG_W-1:0]  disp_tag,
    input  logic              cmp_valid,
    input  logic [TAG_W-1:0]  cmp_tag,
    input  logic [DATA_W-1:0] cmp_value,
    input  logic              cmp_fault,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_addr,
    output logic [DATA_W-1:0] rf_data,
    output logic              exc_valid,
    output logic [TAG_W-1:0]  exc_tag,
    output logic              rob_empty
);

    rob_flags_t        flags_arr [DEPTH];
    logic [REG_W-1:0]  dest_arr  [DEPTH];
    logic [DATA_W-1:0] value_arr [DEPTH];

    logic [TAG_W-1:0] head, tail;
    logic             accept, commit, flush;
    rob_flags_t       head_flags;

    assign head_flags = flags_arr[head];

    rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (disp_valid),
        .head_valid_i (head_flags.valid),
        .head_done_i  (head_flags.done),
        .head_fault_i (head_flags.fault),
        .head_o       (head),
        .tail_o       (tail),
        .accept_o     (accept),
        .commit_o     (commit),
        .flush_o      (flush),
        .ready_o      (disp_ready),
        .empty_o      (rob_empty)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rob_slot #(.REG_W(REG_W), .DATA_W(DATA_W)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .clear_i      (flush),
            .alloc_i      (accept && (tail == TAG_W'(i))),
            .alloc_dest_i (disp_dest),
            .alloc_wen_i  (disp_wen),
            .fill_i       (cmp_valid && (cmp_tag == TAG_W'(i))),
            .fill_value_i (cmp_value),
            .fill_fault_i (cmp_fault),
            .retire_i     (commit && (head == TAG_W'(i))),
            .flags_o      (flags_arr[i]),
            .dest_o       (dest_arr[i]),
            .value_o      (value_arr[i])
        );
    end

    assign disp_tag  = tail;
    assign rf_we     = commit && head_flags.wen;
    assign rf_addr   = dest_arr[head];
    assign rf_data   = value_arr[head];
    assign exc_valid = flush;
    assign exc_tag   = head;

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [TAG_W-1:0] disp_tag,
    input logic             rf_we,
    input logic             exc_valid,
    input logic [TAG_W-1:0] exc_tag,
    input logic             rob_empty
);

    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> disp_tag == TAG_W'($past(disp_tag) + 1'b1)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready && !exc_valid) |=> $stable(disp_tag)); // R3

    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !rf_we); // R7

    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> !exc_valid); // R7

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (rob_empty && disp_tag == $past(exc_tag))); // R8

    AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !disp_ready); // R10

    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rob_empty |-> (!rf_we && !exc_valid && disp_ready)); // R11

endmodule

bind rob_core rob_checker #(.TAG_W(TAG_W)) u_rob_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_tag   (disp_tag),
    .rf_we      (rf_we),
    .exc_valid  (exc_valid),
    .exc_tag    (exc_tag),
    .rob_empty  (rob_empty)
);

// File: tb/test_rob_core.sv
`timescale 1ns/1ps
module test_rob_core;

    localparam int DEPTH  = 8;
    localparam int TAG_W  = 3;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic              disp_valid = 1'b0, disp_wen = 1'b0;
    logic [REG_W-1:0]  disp_dest = '0;
    logic              cmp_valid = 1'b0, cmp_fault = 1'b0;
    logic [TAG_W-1:0]  cmp_tag = '0;
    logic [DATA_W-1:0] cmp_value = '0;
    logic              disp_ready, rf_we, exc_valid, rob_empty;
    logic [TAG_W-1:0]  disp_tag, exc_tag;
    logic [REG_W-1:0]  rf_addr;
    logic [DATA_W-1:0] rf_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) i_rob_core (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_dest(disp_dest), .disp_wen(disp_wen),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value), .cmp_fault(cmp_fault),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .exc_valid(exc_valid), .exc_tag(exc_tag), .rob_empty(rob_empty)
    );

    // bench model of the buffer, built from the requirements
    bit               m_v [DEPTH];
    bit               m_d [DEPTH];
    bit               m_f [DEPTH];
    bit               m_w [DEPTH];
    logic [REG_W-1:0] m_dest [DEPTH];
    logic [31:0]      m_val [DEPTH];
    int m_head = 0, m_tail = 0, m_cnt = 0;

    function automatic bit exp_commit();
        return m_v[m_head] && m_d[m_head] && !m_f[m_head];
    endfunction

    function automatic bit exp_fault();
        return m_v[m_head] && m_d[m_head] && m_f[m_head];
    endfunction

    function automatic bit exp_ready();
        return (m_cnt < DEPTH) && !exp_fault();
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic step(input logic dv, input logic [REG_W-1:0] dd, input logic dw,
                        input logic cv, input logic [TAG_W-1:0] ct,
                        input logic [31:0] cval, input logic cf);
        bit c, f, a;
        disp_valid = dv; disp_dest = dd; disp_wen = dw;
        cmp_valid = cv; cmp_tag = ct; cmp_value = cval; cmp_fault = cf;
        #1;
        c = exp_commit();
        f = exp_fault();
        a = dv && exp_ready();
        chk(f ? "R10" : "R3", "disp_ready", 32'(disp_ready), 32'(exp_ready()));
        chk("R2", "disp_tag", 32'(disp_tag), 32'(m_tail));
        chk("R5", "rf_we", 32'(rf_we), 32'(c && m_w[m_head]));
        if (c && m_w[m_head]) begin
            chk("R5", "rf_addr", 32'(rf_addr), 32'(m_dest[m_head]));
            chk("R5", "rf_data", rf_data, m_val[m_head]);
        end
        chk("R7", "exc_valid", 32'(exc_valid), 32'(f));
        if (f) chk("R7", "exc_tag", 32'(exc_tag), 32'(m_head));
        chk("R11", "rob_empty", 32'(rob_empty), 32'(m_cnt == 0));
        @(posedge clk);
        if (f) begin
            for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
            m_tail = m_head;
            m_cnt = 0;
        end else begin
            if (cv && m_v[ct]) begin
                m_d[ct] = 1; m_f[ct] = cf; m_val[ct] = cval;
            end
            if (c) begin
                m_v[m_head] = 0;
                m_head = (m_head + 1) % DEPTH;
            end
            if (a) begin
                m_v[m_tail] = 1; m_d[m_tail] = 0; m_f[m_tail] = 0;
                m_w[m_tail] = dw; m_dest[m_tail] = dd; m_val[m_tail] = 0;
                m_tail = (m_tail + 1) % DEPTH;
            end
            m_cnt = m_cnt + int'(a) - int'(c);
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, '0, 0, 0, '0, '0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [TAG_W-1:0] t;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "rob_empty", 32'(rob_empty), 1);
        chk("R1", "disp_ready", 32'(disp_ready), 1);
        chk("R1", "disp_tag", 32'(disp_tag), 0);
        chk("R1", "rf_we", 32'(rf_we), 0);
        chk("R1", "exc_valid", 32'(exc_valid), 0);

        // R3: fill to capacity, then a refused request
        for (int i = 0; i < DEPTH; i++) step(1, REG_W'(i + 1), 1, 0, '0, '0, 0);
        step(1, 5'd31, 1, 0, '0, '0, 0);
        chk("R3", "disp_tag after refused request", 32'(disp_tag), 0);

        // R4: younger entries finish first, in reverse order
        for (int i = DEPTH - 1; i >= 1; i--) step(0, '0, 0, 1, TAG_W'(i), 32'h100 + 32'(i), 0);
        chk("R4", "rf_we while oldest unfinished", 32'(rf_we), 0);
        step(0, '0, 0, 1, '0, 32'h100, 0);
        for (int i = 0; i < DEPTH; i++) idle();
        chk("R5", "drained after in-order retirement", 32'(rob_empty), 1);

        // R6: entry without write enable
        t = disp_tag;
        step(1, 5'd3, 0, 0, '0, '0, 0);
        step(0, '0, 0, 1, t, 32'hABCD, 0);
        chk("R6", "rf_we for no-write entry", 32'(rf_we), 0);
        idle();
        chk("R6", "slot freed", 32'(rob_empty), 1);

        // R7/R8/R10: younger fault waits, then flushes at the head
        t = disp_tag;
        for (int i = 0; i < 4; i++) step(1, REG_W'(10 + i), 1, 0, '0, '0, 0);
        step(0, '0, 0, 1, t + 3'd1, 32'hDEAD, 1);
        step(0, '0, 0, 1, t + 3'd2, 32'h2222, 0);
        step(0, '0, 0, 1, t + 3'd3, 32'h3333, 0);
        chk("R7", "younger fault hidden", 32'(exc_valid), 0);
        step(0, '0, 0, 1, t, 32'h1111, 0);
        step(1, 5'd20, 1, 1, t + 3'd3, 32'h4444, 0); // retire oldest
        chk("R7", "exc_tag", 32'(exc_tag), 32'(t + 3'd1));
        chk("R10", "disp_ready in fault cycle", 32'(disp_ready), 0);
        step(1, 5'd21, 1, 1, t + 3'd2, 32'h5555, 0); // fault cycle
        chk("R8", "empty after flush", 32'(rob_empty), 1);
        chk("R8", "tail at faulting slot", 32'(disp_tag), 32'(t + 3'd1));

        // R9: completion into a discarded slot is ignored
        step(0, '0, 0, 1, t + 3'd2, 32'h6666, 0);
        step(1, 5'd7, 1, 0, '0, '0, 0);
        step(1, 5'd8, 1, 0, '0, '0, 0);
        step(0, '0, 0, 1, t + 3'd1, 32'h7777, 0);
        idle();
        chk("R9", "stale completion not kept", 32'(rf_we), 0);
        step(0, '0, 0, 1, t + 3'd2, 32'h8888, 0);
        idle();
        chk("R9", "drained", 32'(rob_empty), 1);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [TAG_W-1:0] ct;
            ct = TAG_W'($urandom % DEPTH);
            if ($urandom % 5 != 0) begin
                for (int k = 0; k < DEPTH; k++) begin
                    if (m_v[ct] && !m_d[ct]) break;
                    ct = ct + 1'b1;
                end
            end
            step(($urandom % 10) < 6, REG_W'($urandom), ($urandom % 4) != 0,
                 ($urandom % 10) < 6, ct, $urandom, ($urandom % 25) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule